// File: doc/BRIEF.md
# Synchronized Tick-Request Handshake Controller

This block is a small control state machine. It sits between a host that sends an asynchronous trigger tick and a remote producer that delivers a parallel data word. A rising edge of the host tick starts one transaction. The controller raises a request toward the producer and keeps it high until the producer pulls its valid level low. It then waits in a busy state until valid goes high again. On that edge it latches the parallel word, pulses a done strobe and returns to idle.

The host tick and the producer valid level are treated as asynchronous. Both pass through a multi-flop synchronizer before any state decision uses them, so an edge that lands on the clock cannot corrupt the state register. The state register is one-hot, and any encoding that is not a legal state sends the machine back to idle. A registered indicator bus shows the current state, with one bit per state, for external observation. The valid handshake works on levels. The producer never has to generate a single-cycle pulse.

Top module: `tkh_ctrl_top`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `req_o` is 0, `done_o` is 0, `word_o` is all zeros and `state_led_o` is 3'b001 (idle).
- R2: `host_tick_i` and `prod_valid_i` each pass through a 2-flop synchronizer. A host tick edge that is set up before clock edge k makes `req_o` go high after edge k+2 and not earlier.
- R3: Each rising edge of the synchronized tick seen in idle starts exactly one transaction. A tick held high never starts a second one.
- R4: `req_o` stays high until the synchronized valid is seen low. A falling `prod_valid_i` that is set up before edge k clears `req_o` after edge k+2.
- R5: After the request is released, the controller waits with no timeout for valid to return high. A rising `prod_valid_i` that is set up before edge k loads `prod_word_i` into `word_o` after edge k+2.
- R6: `done_o` is high for exactly one cycle, the same cycle in which the new word first appears on `word_o`.
- R7: A tick rising edge that arrives while the controller is requesting or waiting has no effect. It does not raise `req_o` after the transaction ends.
- R8: `state_led_o` is one-hot: bit0 = idle, bit1 = requesting, bit2 = waiting for valid. Any illegal state encoding returns the machine to idle with the indicator at 3'b001.
- R9: `word_o` changes only when `done_o` is high. Activity on `prod_word_i` at any other time leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| host_tick_i | input | 1 | Asynchronous trigger from the host |
| prod_valid_i | input | 1 | Asynchronous valid level from the producer |
| prod_word_i | input | 12 | Parallel word from the producer |
| req_o | output | 1 | Request strobe to the producer |
| word_o | output | 12 | Last captured word |
| done_o | output | 1 | One-cycle capture strobe |
| state_led_o | output | 3 | One-hot state indicator |

## Verification
A wrong state would show on the indicator bus and on `req_o` on the same clock as the state change, because both are registered from the next-state value. A machine stuck requesting or busy keeps `req_o` high, or keeps the indicator at 3'b100, past the third edge after the valid input changes. The bench checks those exact edges. A spurious restart from a tick edge during a transaction shows as `req_o` rising within three cycles after `done_o`. A bad capture shows as a wrong `word_o` in the done cycle, or as `word_o` moving while the producer word is scrambled.

// File: rtl/tkh_pkg.sv
package tkh_pkg;
  localparam int unsigned NSTATE = 3;

  typedef enum logic [NSTATE-1:0] {
    ST_IDLE = 3'b001,
    ST_REQ  = 3'b010,
    ST_BUSY = 3'b100
  } tkh_state_t;
endpackage

// File: rtl/tkh_sync.sv
module tkh_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else if (STAGES == 1) chain_q <= async_i[b];
      else chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[LAST];
  end
endmodule

// File: rtl/tkh_rise.sv
module tkh_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/tkh_fsm.sv
module tkh_fsm
  import tkh_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_rise_i,
  input  logic              valid_s_i,
  output logic              req_o,
  output logic              cap_o,
  output logic [NSTATE-1:0] led_o
);
  tkh_state_t       state_q, state_d;
  logic             req_q;
  logic [NSTATE-1:0] led_q;

  always_comb begin
    state_d = state_q;
    cap_o   = 1'b0;
    case (state_q)
      ST_IDLE: if (tick_rise_i) state_d = ST_REQ;
      ST_REQ:  if (!valid_s_i) state_d = ST_BUSY;
      ST_BUSY: if (valid_s_i) begin
        cap_o   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      led_q   <= ST_IDLE;
    end else begin
      state_q <= state_d;
      req_q   <= (state_d == ST_REQ);
      case (state_d)
        ST_REQ:  led_q <= ST_REQ;
        ST_BUSY: led_q <= ST_BUSY;
        default: led_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o = req_q;
  assign led_o = led_q;

  assert_req_start_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(req_q) |-> $past(tick_rise_i) && ($past(state_q) == ST_IDLE));

  assert_req_release_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(req_q) |-> !$past(valid_s_i));

  assert_busy_wait_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BUSY && !valid_s_i) |=> (state_q == ST_BUSY));

  assert_led_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot(led_q));
endmodule

// File: rtl/tkh_capture.sv
module tkh_capture #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);
  logic [WORD_W-1:0] word_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= cap_i;
      if (cap_i) word_q <= word_i;
    end
  end

  assign word_o = word_q;
  assign done_o = done_q;

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
endmodule

// File: rtl/tkh_ctrl_top.sv
module tkh_ctrl_top
  import tkh_pkg::*;
#(
  parameter int unsigned WORD_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_tick_i,
  input  logic              prod_valid_i,
  input  logic [WORD_W-1:0] prod_word_i,
  output logic              req_o,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o,
  output logic [NSTATE-1:0] state_led_o
);
  localparam int unsigned N_ASYNC = 2;

  logic [N_ASYNC-1:0] sync_s;
  logic               tick_rise;
  logic               cap;

  tkh_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({prod_valid_i, host_tick_i}),
    .sync_o  (sync_s)
  );

  tkh_rise u_rise (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (sync_s[0]),
    .rise_o (tick_rise)
  );

  tkh_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .tick_rise_i (tick_rise),
    .valid_s_i   (sync_s[1]),
    .req_o       (req_o),
    .cap_o       (cap),
    .led_o       (state_led_o)
  );

  tkh_capture #(.WORD_W(WORD_W)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .cap_i  (cap),
    .word_i (prod_word_i),
    .word_o (word_o),
    .done_o (done_o)
  );

  assert_word_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(word_o));

  assert_done_no_req_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !req_o);
endmodule

// File: tb/test_tkh_ctrl_top.sv
`timescale 1ns/1ps
module test_tkh_ctrl_top;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         host_tick_i = 1'b0;
  logic         prod_valid_i = 1'b1;
  logic [W-1:0] prod_word_i = '0;
  logic         req_o;
  logic [W-1:0] word_o;
  logic         done_o;
  logic [2:0]   state_led_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tkh_ctrl_top i_tkh_ctrl_top (
    .clk          (clk),
    .rst          (rst),
    .host_tick_i  (host_tick_i),
    .prod_valid_i (prod_valid_i),
    .prod_word_i  (prod_word_i),
    .req_o        (req_o),
    .word_o       (word_o),
    .done_o       (done_o),
    .state_led_o  (state_led_o)
  );

  function automatic logic [2:0] led_of(int st);
    return 3'(1 << st);
  endfunction

  function automatic logic [W-1:0] rand_word();
    return W'($urandom);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic nclk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [W-1:0] held;

  task automatic transaction(int dly_low, int dly_high, bit noise);
    logic [W-1:0] w;
    w = rand_word();
    host_tick_i = 1'b1;
    nclk(2);
    chk(req_o == 1'b0, "R2 early req", 32'(req_o), 0);
    nclk(1);
    chk(req_o == 1'b1, "R2 req rise", 32'(req_o), 1);
    chk(state_led_o == led_of(1), "R8 led req", 32'(state_led_o), 32'(led_of(1)));
    for (int i = 0; i < dly_low; i++) begin
      nclk(1);
      chk(req_o == 1'b1, "R4 req hold", 32'(req_o), 1);
    end
    prod_valid_i = 1'b0;
    nclk(2);
    chk(req_o == 1'b1, "R4 req before sync", 32'(req_o), 1);
    nclk(1);
    chk(req_o == 1'b0, "R4 req release", 32'(req_o), 0);
    chk(state_led_o == led_of(2), "R8 led busy", 32'(state_led_o), 32'(led_of(2)));
    if (noise) begin
      host_tick_i = 1'b0;
      nclk(3);
      host_tick_i = 1'b1;
    end
    for (int i = 0; i < dly_high; i++) begin
      prod_word_i = rand_word();
      nclk(1);
      chk(done_o == 1'b0 && word_o == held, "R9 word hold busy", 32'(word_o), 32'(held));
      chk(req_o == 1'b0, "R7 no req while busy", 32'(req_o), 0);
    end
    prod_word_i = w;
    prod_valid_i = 1'b1;
    nclk(2);
    chk(done_o == 1'b0, "R5 early done", 32'(done_o), 0);
    nclk(1);
    chk(done_o == 1'b1, "R6 done", 32'(done_o), 1);
    chk(word_o == w, "R5 captured word", 32'(word_o), 32'(w));
    chk(state_led_o == led_of(0), "R8 led idle", 32'(state_led_o), 32'(led_of(0)));
    held = w;
    nclk(1);
    chk(done_o == 1'b0, "R6 done one cycle", 32'(done_o), 0);
    for (int i = 0; i < 6; i++) begin
      prod_word_i = rand_word();
      nclk(1);
      chk(req_o == 1'b0, "R3 R7 no retrigger", 32'(req_o), 0);
      chk(word_o == held, "R9 word hold idle", 32'(word_o), 32'(held));
    end
    host_tick_i = 1'b0;
    nclk(4);
  endtask

  initial begin
    void'($urandom(32'd2024));
    held = '0;
    nclk(1);
    nclk(3);
    chk(req_o == 0 && done_o == 0 && word_o == 0, "R1 reset outputs", {req_o, done_o, word_o}, 0);
    chk(state_led_o == led_of(0), "R1 reset led", 32'(state_led_o), 32'(led_of(0)));
    rst = 1'b0;
    nclk(1);
    chk(req_o == 0 && done_o == 0 && word_o == 0, "R1 after release", {req_o, done_o, word_o}, 0);
    nclk(4);
    transaction(0, 8, 1'b0);
    transaction(5, 10, 1'b1);
    for (int t = 0; t < 25; t++)
      transaction(int'($urandom_range(0, 12)), 8 + int'($urandom_range(0, 12)), 1'($urandom));
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule